// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Rounded, Saturating Store

This block is a multiply-accumulate datapath for signed fixed-point fractions. Each operand is an N-bit value with one sign bit and N-1 fraction bits, so it covers -1 up to, but not including, +1. In every clock cycle the block can take one operand pair and form the exact product. The product is doubled so that the radix point lines up with the operands. The block then clears the accumulator, adds the product to it, subtracts the product from it, or loads the product into it.

The accumulator is wider than the product by a set of guard bits. Partial sums can therefore pass beyond ±1 without loss, for as long as the guard bits hold them.

A separate store strobe converts the accumulator to an N-bit result. The rounding mode is chosen per store: plain truncation, round half upward, or round half to even. The conversion clamps to the extreme representable values when the rounded value does not fit. Every clamp sets a sticky overflow flag, and the flag stays set until it is explicitly cleared.

Top module: `frac_mac`

## Requirements
- R1: The product equals opa × opb × 2 at full 2N-bit precision. The one exception is opa = opb = -2^(N-1), whose product becomes the largest positive product, 2^(2N-1)-1.
- R2: The op input is decoded as follows: 0 holds the accumulator, 1 clears it to zero, 2 adds the product, 3 subtracts the product and 4 loads the product. Codes 5 to 7 hold the accumulator. One operation is accepted on every clock edge.
- R3: The accumulator is 2N+G bits wide and wraps modulo 2^(2N+G). Sums of up to 2^G in magnitude survive and can be brought back into range by later operations.
- R4: A store samples the accumulator as it stood before the same edge's operation. It presents result and a one-cycle result_vld after that edge. Without a store, result keeps its value and result_vld is 0.
- R5: Rounding mode 0 (and mode 3) truncates: the kept part is the accumulator shifted right arithmetically by N bits, and the discarded bits are dropped.
- R6: Rounding mode 1 adds one to the kept part when the discarded N bits are at or above one half (their top bit set).
- R7: Rounding mode 2 adds one when the discarded part is above one half. When it is exactly one half, it adds one only if the kept LSB is 1.
- R8: A rounded value above 2^(N-1)-1 stores as 2^(N-1)-1. A rounded value below -2^(N-1) stores as -2^(N-1).
- R9: ovf sets on every store that clamps and stays set until ovf_clr is high at an edge. A clamp on the same edge as ovf_clr leaves ovf set.
- R10: After reset the accumulator is 0, and result, result_vld and ovf are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| opa | input | DATA_W | Signed fractional operand A |
| opb | input | DATA_W | Signed fractional operand B |
| op | input | 3 | Accumulator operation code |
| rnd_mode | input | 2 | Rounding mode for the store path |
| store | input | 1 | Convert the accumulator to a result on this edge |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| result | output | DATA_W | Rounded, saturated result |
| result_vld | output | 1 | Result written on the previous edge |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with DATA_W = 8 and GUARD_W = 4. With these values a few operations are enough to saturate in both directions, to overflow past the guard bits and wrap, and to reach every exact-half rounding case through small operand pairs. The default 24-bit, 8-guard configuration is only elaborated. It behaves the same way, but its corner cases lie much farther apart.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_LOAD  = 3'd4
  } mac_op_e;

  typedef enum logic [1:0] {
    RND_TRUNC  = 2'd0,
    RND_NEAR   = 2'd1,
    RND_CONV   = 2'd2,
    RND_TRUNC2 = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/frac_mult.sv
module frac_mult #(
  parameter int W = 24
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] raw;
  logic                 both_min;

  always_comb begin
    a_ext    = {{W{a[W-1]}}, a};
    b_ext    = {{W{b[W-1]}}, b};
    raw      = a_ext * b_ext;
    both_min = (a == {1'b1, {(W-1){1'b0}}}) && (b == {1'b1, {(W-1){1'b0}}});
    if (both_min) prod = {1'b0, {(PW-1){1'b1}}};
    else          prod = raw <<< 1;
  end

  // R1
  always_comb begin
    product_sign_chk: assert ((a == '0 || b == '0) ? (prod == '0) : 1'b1)
      else $error("zero operand gave nonzero product");
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import frac_mac_pkg::*;
#(
  parameter int PW = 48,
  parameter int AW = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prod,
  input  logic [2:0]    op,
  output logic [AW-1:0] acc
);
  localparam int EXT = AW - PW;

  logic [AW-1:0] prod_ext;
  logic [AW-1:0] acc_d;
  logic          acc_en;

  always_comb begin
    prod_ext = {{EXT{prod[PW-1]}}, prod};
    acc_en   = 1'b1;
    acc_d    = acc;
    case (op)
      OP_CLEAR: acc_d = '0;
      OP_ADD:   acc_d = acc + prod_ext;
      OP_SUB:   acc_d = acc - prod_ext;
      OP_LOAD:  acc_d = prod_ext;
      default:  acc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_d;
  end

  // R2
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLEAR) |=> (acc == '0))
    else $error("clear left accumulator nonzero");

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD || op > 3'd4) |=> $stable(acc))
    else $error("hold code changed accumulator");

  // R2
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (acc[PW-1:0] == $past(prod)))
    else $error("load did not capture product");
endmodule

// File: rtl/store_round.sv
module store_round
  import frac_mac_pkg::*;
#(
  parameter int W  = 24,
  parameter int AW = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc,
  input  logic [1:0]    rnd_mode,
  input  logic          store,
  input  logic          ovf_clr,
  output logic [W-1:0]  result,
  output logic          result_vld,
  output logic          ovf
);
  localparam int KW = AW - W;

  logic [KW-1:0] kept;
  logic [W-1:0]  disc;
  logic          inc;
  logic [KW:0]   rounded;
  logic          fits;
  logic [W-1:0]  sat_val;
  logic          clamp;
  logic [W-1:0]  res_d;
  logic          vld_d;
  logic          ovf_d;

  always_comb begin
    kept = acc[AW-1:W];
    disc = acc[W-1:0];
    case (rnd_mode)
      RND_NEAR: inc = disc[W-1];
      RND_CONV: inc = disc[W-1] & ((|disc[W-2:0]) | kept[0]);
      default:  inc = 1'b0;
    endcase
    rounded = {kept[KW-1], kept} + {{KW{1'b0}}, inc};
    fits    = (~|rounded[KW:W-1]) | (&rounded[KW:W-1]);
    clamp   = ~fits;
    if (fits)             sat_val = rounded[W-1:0];
    else if (rounded[KW]) sat_val = {1'b1, {(W-1){1'b0}}};
    else                  sat_val = {1'b0, {(W-1){1'b1}}};
  end

  always_comb begin
    res_d = store ? sat_val : result;
    vld_d = store;
    ovf_d = (ovf & ~ovf_clr) | (store & clamp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_vld <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      result     <= res_d;
      result_vld <= vld_d;
      ovf        <= ovf_d;
    end
  end

  // R4
  store_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> result_vld)
    else $error("store without valid");

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store |=> ($stable(result) && !result_vld))
    else $error("result moved without store");

  // R9
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(store))
    else $error("overflow rose without a store");

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf)
    else $error("overflow flag dropped without clear");
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int GUARD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [2:0]        op,
  input  logic [1:0]        rnd_mode,
  input  logic              store,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] result,
  output logic              result_vld,
  output logic              ovf
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  logic [1:0]        rst_sync;
  logic              srst_n;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  frac_mult #(.W(DATA_W)) u_mult (
    .a    (opa),
    .b    (opb),
    .prod (prod)
  );

  mac_accum #(.PW(PROD_W), .AW(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (srst_n),
    .prod  (prod),
    .op    (op),
    .acc   (acc)
  );

  store_round #(.W(DATA_W), .AW(ACC_W)) u_store (
    .clk        (clk),
    .rst_n      (srst_n),
    .acc        (acc),
    .rnd_mode   (rnd_mode),
    .store      (store),
    .ovf_clr    (ovf_clr),
    .result     (result),
    .result_vld (result_vld),
    .ovf        (ovf)
  );
endmodule

// File: tb/frac_mac_test.sv
module frac_mac_test;
  localparam int N     = 8;
  localparam int G     = 4;
  localparam int AW    = 2 * N + G;
  localparam int WDOG  = 20000;

  typedef struct {
    int    res;
    bit    ov;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] opa, opb;
  logic [2:0]   op;
  logic [1:0]   rnd_mode;
  logic         store, ovf_clr;
  logic [N-1:0] result;
  logic         result_vld, ovf;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  exp_t  sb[$];
  longint acc_m   = 0;
  bit    ovf_m    = 1'b0;

  always #4 clk = ~clk;

  frac_mac #(.DATA_W(N), .GUARD_W(G)) uut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op),
    .rnd_mode(rnd_mode), .store(store), .ovf_clr(ovf_clr),
    .result(result), .result_vld(result_vld), .ovf(ovf)
  );

  function automatic longint wrap_acc(longint v);
    longint m;
    m = v & ((64'sd1 <<< AW) - 1);
    if (m >= (64'sd1 <<< (AW - 1))) m = m - (64'sd1 <<< AW);
    return m;
  endfunction

  function automatic longint prod_m(int a, int b);
    if (a == -128 && b == -128) return 32767;
    return longint'(a) * longint'(b) * 2;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int o, int a, int b, bit st, int rm, bit clr, string tag);
    longint k, d, r, p;
    bit     cl;
    exp_t   e;
    @(negedge clk);
    opa = N'(a); opb = N'(b); op = 3'(o); store = st; rnd_mode = 2'(rm); ovf_clr = clr;
    if (st) begin
      k = acc_m >>> N;
      d = acc_m & ((64'sd1 <<< N) - 1);
      r = k;
      if (rm == 1 && d >= 128) r = k + 1;
      if (rm == 2 && (d > 128 || (d == 128 && (k & 1) == 1))) r = k + 1;
      cl = 1'b0;
      if (r > 127)  begin r = 127;  cl = 1'b1; end
      if (r < -128) begin r = -128; cl = 1'b1; end
      ovf_m = (ovf_m && !clr) || cl;
      e.res = int'(r); e.ov = ovf_m; e.tag = tag;
      sb.push_back(e);
    end else if (clr) begin
      ovf_m = 1'b0;
    end
    p = prod_m(a, b);
    case (o)
      1: acc_m = 0;
      2: acc_m = wrap_acc(acc_m + p);
      3: acc_m = wrap_acc(acc_m - p);
      4: acc_m = wrap_acc(p);
      default: ;
    endcase
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && result_vld) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4 unexpected valid", 1, 0);
        end else begin
          e = sb.pop_front();
          check($signed(result) == e.res, e.tag, $signed(result), e.res);
          check(ovf == e.ov, {e.tag, " ovf"}, int'(ovf), int'(e.ov));
        end
      end
    end
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; opa = '0; opb = '0; op = '0; rnd_mode = '0; store = 1'b0; ovf_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(result == '0, "R10 result", int'(result), 0);
    check(result_vld == 1'b0, "R10 valid", int'(result_vld), 0);
    check(ovf == 1'b0, "R10 ovf", int'(ovf), 0);
    step(0, 0, 0, 1, 0, 0, "R10 accumulator");

    // R1 / R5: 0.5 * 0.5 = 0.25
    step(4, 64, 64, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 0, "R1 half squared");
    // R1 / R8: -1 * -1 saturates
    step(4, -128, -128, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 0, "R1 min times min");
    step(0, 0, 0, 1, 1, 0, "R8 positive clamp");
    step(0, 0, 0, 1, 0, 0, "R9 sticky");
    step(0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 0, 0, "R9 cleared");
    step(0, 0, 0, 1, 1, 1, "R9 clamp beats clear");
    step(1, 0, 0, 0, 0, 1, "R9");

    // exact halves
    step(4, 1, 64, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 0, "R5 half trunc");
    step(0, 0, 0, 1, 1, 0, "R6 half up");
    step(0, 0, 0, 1, 2, 0, "R7 half to even 0");
    step(0, 0, 0, 1, 3, 0, "R5 mode3 trunc");
    step(2, 2, 64, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 0, "R6 1.5 up");
    step(0, 0, 0, 1, 2, 0, "R7 odd half up");
    step(4, -1, 64, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 0, "R5 negative floor");
    step(0, 0, 0, 1, 1, 0, "R6 negative half");
    step(0, 0, 0, 1, 2, 0, "R7 negative half");
    step(3, 2, 64, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 0, "R6 -1.5");
    step(0, 0, 0, 1, 2, 0, "R7 -1.5 even");
    step(4, 1, 65, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 2, 0, "R7 above half");
    step(4, 1, 63, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 2, 0, "R7 below half");

    // R4 store sees pre-edge accumulator
    step(4, 10, 10, 0, 0, 0, "R4");
    step(4, 20, 20, 1, 0, 0, "R4 same edge load");
    step(0, 0, 0, 1, 0, 0, "R4 after load");

    // R2 hold codes and clear
    step(5, 50, 50, 0, 0, 0, "R2");
    step(6, 50, 50, 0, 0, 0, "R2");
    step(7, 50, 50, 1, 0, 0, "R2 reserved codes hold");
    step(1, 0, 0, 1, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 0, "R2 cleared");

    // R3 guard bits and wrap, R8 both directions
    step(4, 127, 127, 0, 0, 1, "R3");
    for (int i = 0; i < 7; i++) step(2, 127, 127, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, "R8 guard saturate");
    for (int i = 0; i < 8; i++) step(3, 127, 127, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 1, 1, "R3 recovered");
    for (int i = 0; i < 17; i++) step(2, 127, 127, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 0, "R3 wrap");
    step(4, -128, 127, 0, 0, 1, "R8");
    for (int i = 0; i < 3; i++) step(2, -128, 127, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 2, 0, "R8 negative clamp");

    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)) - 128,
           int'($urandom_range(0, 255)) - 128, 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 3)), ($urandom_range(0, 9) == 0), "R2 mixed");

    step(0, 0, 0, 0, 0, 0, "R4");
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R4 missing results", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule